// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting channel of an interval timer. A count value and an operating mode are loaded together through a one-cycle load strobe. A count-enable strobe, one clock wide and synchronous to the system clock, advances the counter. A gate input either holds counting or restarts it on a rising edge, depending on the mode. The channel drives one output line, OUT, whose waveform depends on the mode: an interrupt on terminal count, a retriggerable one-shot, a rate generator, a square wave, or a strobe started by software or by hardware. The present count is always visible on a parallel output, so an enclosing bus interface can latch and serialise it.

The mode code is sampled only when a count is loaded. Codes 6 and 7 behave as codes 2 and 3. A loaded value of zero stands for the full counter range, 2^CNT_W ticks. The clock domain uses an asynchronous active-low reset that is released synchronously inside the block.

Top module: `ivc_channel`

## Requirements
- R1: After reset the count output is 0 and OUT is 1. Count-enable strobes have no effect on either output until a count is loaded.
- R2: A loaded value of 0 acts as 2^CNT_W ticks. In mode 0 with value 0, OUT rises only after the 65536th enabled tick, and the count wraps through 0xFFFF on the way.
- R3: Mode 0: the load sets OUT to 0 and the count to the loaded value. Each enabled tick subtracts 1, modulo 2^CNT_W. OUT becomes 1 on the tick that brings the count to 0 and then stays 1 until the next load.
- R4: Mode 1: a gate rising edge sets OUT to 0 and the count to the stored value. Ticks subtract 1. OUT becomes 1 when the count reaches 0 and stays 1 until retriggered.
- R5: Mode 2 with value N: OUT is 0 for exactly one tick period each cycle of N ticks. The tick that moves the count from 2 to 1 sets OUT to 0. The next tick reloads N and sets OUT to 1.
- R6: Mode 3 with value N: the count falls by 2 per tick and stays even. OUT is 1 for (N+1)/2 ticks and 0 for N/2 ticks (integer division), and each half starts from a fresh reload.
- R7: Modes 4 and 5: OUT is 1 except for one tick period. That period begins on the tick that brings the count to 0 after a start. Later wraps of the count through 0 do not pulse OUT again.
- R8: A gate rising edge restarts the count from the stored value in modes 1, 2, 3 and 5. In modes 0 and 4 a gate rising edge changes neither the count nor OUT.
- R9: In modes 0, 2, 3 and 4 the count and OUT hold while the gate is low. In modes 1 and 5 the gate level does not affect counting.
- R10: Mode codes 6 and 7 give the same count and OUT sequences as codes 2 and 3.
- R11: In modes 0 and 4, a load restarts at once from the new value. In the other modes, a load restarts at once only if it is the first load after reset or its mode differs from the held mode; mode 1 and mode 5 then wait, with OUT at 1, for a gate rising edge. A load with the same mode in modes 1, 2, 3 and 5 leaves the count and OUT unchanged, and the new value is used at the next reload or trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-enable strobe, one clock per tick |
| gate_in | input | 1 | Gate level, sampled every clock for rising edges |
| load_stb | input | 1 | Loads load_val and mode_sel in this cycle |
| load_val | input | CNT_W | Count value to load (0 means full range) |
| mode_sel | input | 3 | Mode code 0 to 7 |
| count_o | output | CNT_W | Present count |
| out_o | output | 1 | Mode-dependent output line |

## Verification
A wrong count or reload register shows on count_o one clock after the enabled tick that uses it. It also moves the OUT edge in modes 0, 2, 3 and 4 by the same number of ticks. A stuck fired flag shows as a second OUT pulse when the count next wraps through zero, 2^CNT_W ticks later. That is why one case runs a full wrap. A wrong mode-match decision for loads shows at once, because the count jumps when it should have held, or holds when it should have jumped, in the cycle after the load.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } ivc_mode_e;

  // codes 6 and 7 fold onto 2 and 3
  function automatic ivc_mode_e fold_mode(input logic [2:0] code);
    if (code[2] && code[1]) return ivc_mode_e'({1'b0, code[1:0]});
    return ivc_mode_e'(code);
  endfunction

  function automatic logic mode_retrig(input ivc_mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTROBE);
  endfunction

  function automatic logic mode_gate_free(input ivc_mode_e m);
    return (m == M_ONESHOT) || (m == M_HWSTROBE);
  endfunction

endpackage

// File: rtl/ivc_rst_sync.sv
module ivc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ivc_gate_edge.sv
module ivc_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  output logic gate_rise
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_in;
  end

  assign gate_rise = gate_in & ~gate_q;
endmodule

// File: rtl/ivc_next.sv
module ivc_next
  import ivc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             tick_en,
  input  logic             gate_lvl,
  input  logic             gate_rise,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  ivc_mode_e        mode_in,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] reld_q,
  input  ivc_mode_e        mode_q,
  input  logic             cfg_q,
  input  logic             run_q,
  input  logic             out_q,
  input  logic             fired_q,
  output logic [CNT_W-1:0] cnt_n,
  output logic [CNT_W-1:0] reld_n,
  output ivc_mode_e        mode_n,
  output logic             cfg_n,
  output logic             run_n,
  output logic             out_n,
  output logic             fired_n
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic             fresh;
  logic             cnt_en;
  logic [CNT_W-1:0] sq_hi;
  logic [CNT_W-1:0] sq_lo;
  logic [CNT_W-1:0] ld_sq_hi;

  always_comb begin
    fresh    = !cfg_q || (mode_in != mode_q);
    cnt_en   = run_q && tick_en && (gate_lvl || mode_gate_free(mode_q));
    sq_hi    = reld_q + CNT_W'(reld_q[0]);
    sq_lo    = {reld_q[CNT_W-1:1], 1'b0};
    ld_sq_hi = load_val + CNT_W'(load_val[0]);

    cnt_n   = cnt_q;
    reld_n  = reld_q;
    mode_n  = mode_q;
    cfg_n   = cfg_q;
    run_n   = run_q;
    out_n   = out_q;
    fired_n = fired_q;

    if (load_stb) begin
      reld_n = load_val;
      mode_n = mode_in;
      cfg_n  = 1'b1;
      if (fresh || mode_in == M_TERM || mode_in == M_SWSTROBE) begin
        fired_n = 1'b0;
        unique case (mode_in)
          M_TERM:     begin cnt_n = load_val; out_n = 1'b0; run_n = 1'b1; end
          M_SWSTROBE: begin cnt_n = load_val; out_n = 1'b1; run_n = 1'b1; end
          M_RATE:     begin cnt_n = load_val; out_n = 1'b1; run_n = 1'b1; end
          M_SQUARE:   begin cnt_n = ld_sq_hi; out_n = 1'b1; run_n = 1'b1; end
          default:    begin out_n = 1'b1; run_n = 1'b0; end
        endcase
      end
    end else if (gate_rise && cfg_q && mode_retrig(mode_q)) begin
      fired_n = 1'b0;
      run_n   = 1'b1;
      unique case (mode_q)
        M_ONESHOT: begin cnt_n = reld_q; out_n = 1'b0; end
        M_SQUARE:  begin cnt_n = sq_hi;  out_n = 1'b1; end
        default:   begin cnt_n = reld_q; out_n = 1'b1; end
      endcase
    end else if (cnt_en) begin
      unique case (mode_q)
        M_TERM, M_ONESHOT: begin
          cnt_n = cnt_q - ONE;
          if (cnt_q == ONE) out_n = 1'b1;
        end
        M_RATE: begin
          if (cnt_q == ONE) begin
            cnt_n = reld_q;
            out_n = 1'b1;
          end else begin
            cnt_n = cnt_q - ONE;
            out_n = (cnt_q != TWO);
          end
        end
        M_SQUARE: begin
          if (cnt_q == TWO) begin
            out_n = !out_q;
            cnt_n = out_q ? sq_lo : sq_hi;
          end else begin
            cnt_n = cnt_q - TWO;
          end
        end
        default: begin
          cnt_n = cnt_q - ONE;
          if (cnt_q == ONE && !fired_q) begin
            out_n   = 1'b0;
            fired_n = 1'b1;
          end else begin
            out_n = 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ivc_channel.sv
module ivc_channel
  import ivc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             gate_in,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  input  logic [2:0]       mode_sel,
  output logic [CNT_W-1:0] count_o,
  output logic             out_o
);
  logic             rst_n_s;
  logic             gate_rise;
  ivc_mode_e        mode_in;
  logic [CNT_W-1:0] cnt_q, cnt_n, reld_q, reld_n;
  ivc_mode_e        mode_q, mode_n;
  logic             cfg_q, cfg_n, run_q, run_n, out_q, out_n, fired_q, fired_n;

  assign mode_in = fold_mode(mode_sel);

  ivc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  ivc_gate_edge u_gate (
    .clk(clk), .rst_n(rst_n_s), .gate_in(gate_in), .gate_rise(gate_rise)
  );

  ivc_next #(.CNT_W(CNT_W)) u_next (
    .tick_en(tick_en), .gate_lvl(gate_in), .gate_rise(gate_rise),
    .load_stb(load_stb), .load_val(load_val), .mode_in(mode_in),
    .cnt_q(cnt_q), .reld_q(reld_q), .mode_q(mode_q), .cfg_q(cfg_q),
    .run_q(run_q), .out_q(out_q), .fired_q(fired_q),
    .cnt_n(cnt_n), .reld_n(reld_n), .mode_n(mode_n), .cfg_n(cfg_n),
    .run_n(run_n), .out_n(out_n), .fired_n(fired_n)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cnt_q   <= '0;
      reld_q  <= '0;
      mode_q  <= M_TERM;
      cfg_q   <= 1'b0;
      run_q   <= 1'b0;
      out_q   <= 1'b1;
      fired_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      reld_q  <= reld_n;
      mode_q  <= mode_n;
      cfg_q   <= cfg_n;
      run_q   <= run_n;
      out_q   <= out_n;
      fired_q <= fired_n;
    end
  end

  assign count_o = cnt_q;
  assign out_o   = out_q;
endmodule

// File: rtl/ivc_channel_chk.sv
module ivc_channel_chk
  import ivc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             load_stb,
  input logic             gate_rise,
  input ivc_mode_e        mode_q,
  input logic             run_q,
  input logic [CNT_W-1:0] count_o,
  input logic             out_o
);
  // R3
  term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TERM && out_o && !load_stb) |=> out_o);

  // R3
  term_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_o) && mode_q == M_TERM) |-> (count_o == '0));

  // R7
  strobe_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(out_o) && (mode_q == M_SWSTROBE || mode_q == M_HWSTROBE)) |-> (count_o == '0));

  // R6
  square_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SQUARE && run_q) |-> (count_o[0] == 1'b0));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_stb && !gate_rise) |=> $stable(count_o));
endmodule

bind ivc_channel ivc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .tick_en(tick_en), .load_stb(load_stb),
  .gate_rise(gate_rise), .mode_q(mode_q), .run_q(run_q),
  .count_o(count_o), .out_o(out_o)
);

// File: tb/sim_ivc_channel.sv
`timescale 1ns/1ps
module sim_ivc_channel;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tick_en, gate_in, load_stb;
  logic [W-1:0] load_val;
  logic [2:0]   mode_sel;
  logic [W-1:0] count_o;
  logic         out_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ivc_channel #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate_in(gate_in),
    .load_stb(load_stb), .load_val(load_val), .mode_sel(mode_sel),
    .count_o(count_o), .out_o(out_o)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [15:0] val;
    logic [16:0] ticks;
    logic [15:0] cnt;
    logic        out;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'd5, 17'd3,     16'd2,      1'b0, 4'd3},  // R3
    '{3'd0, 16'd5, 17'd5,     16'd0,      1'b1, 4'd3},  // R3
    '{3'd0, 16'd5, 17'd7,     16'hFFFE,   1'b1, 4'd3},  // R3
    '{3'd0, 16'd0, 17'd2,     16'hFFFE,   1'b0, 4'd2},  // R2
    '{3'd0, 16'd0, 17'd65536, 16'd0,      1'b1, 4'd2},  // R2
    '{3'd1, 16'd4, 17'd0,     16'd4,      1'b0, 4'd4},  // R4
    '{3'd1, 16'd4, 17'd3,     16'd1,      1'b0, 4'd4},  // R4
    '{3'd1, 16'd4, 17'd4,     16'd0,      1'b1, 4'd4},  // R4
    '{3'd2, 16'd4, 17'd3,     16'd1,      1'b0, 4'd5},  // R5
    '{3'd2, 16'd4, 17'd4,     16'd4,      1'b1, 4'd5},  // R5
    '{3'd2, 16'd4, 17'd6,     16'd2,      1'b1, 4'd5},  // R5
    '{3'd2, 16'd4, 17'd7,     16'd1,      1'b0, 4'd5},  // R5
    '{3'd3, 16'd6, 17'd3,     16'd6,      1'b0, 4'd6},  // R6
    '{3'd3, 16'd6, 17'd6,     16'd6,      1'b1, 4'd6},  // R6
    '{3'd3, 16'd5, 17'd3,     16'd4,      1'b0, 4'd6},  // R6
    '{3'd3, 16'd5, 17'd5,     16'd6,      1'b1, 4'd6},  // R6
    '{3'd3, 16'd5, 17'd2,     16'd2,      1'b1, 4'd6},  // R6
    '{3'd4, 16'd3, 17'd2,     16'd1,      1'b1, 4'd7},  // R7
    '{3'd4, 16'd3, 17'd3,     16'd0,      1'b0, 4'd7},  // R7
    '{3'd4, 16'd3, 17'd4,     16'hFFFF,   1'b1, 4'd7},  // R7
    '{3'd5, 16'd3, 17'd3,     16'd0,      1'b0, 4'd7},  // R7
    '{3'd5, 16'd3, 17'd4,     16'hFFFF,   1'b1, 4'd7},  // R7
    '{3'd6, 16'd4, 17'd3,     16'd1,      1'b0, 4'd10}, // R10
    '{3'd7, 16'd6, 17'd3,     16'd6,      1'b0, 4'd10}  // R10
  };

  task automatic chk(input string req, input logic [W-1:0] exp_cnt, input logic exp_out);
    checks++;
    if (count_o !== exp_cnt || out_o !== exp_out) begin
      failures++;
      $display("FAIL %s count=%h expected=%h out=%b expected=%b",
               req, count_o, exp_cnt, out_o, exp_out);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b0; gate_in = 1'b0; load_stb = 1'b0;
    load_val = '0; mode_sel = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_load(input logic [2:0] m, input logic [W-1:0] v);
    load_stb = 1'b1; mode_sel = m; load_val = v;
    @(negedge clk);
    load_stb = 1'b0;
  endtask

  task automatic set_gate(input logic g);
    gate_in = g;
    @(negedge clk);
  endtask

  task automatic do_ticks(input int n);
    if (n > 0) begin
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; gate_in = 1'b0; load_stb = 1'b0;
    load_val = '0; mode_sel = '0;

    // R1: reset state, ticks without a load do nothing
    do_reset();
    chk("R1 reset", 16'd0, 1'b1);
    set_gate(1'b1);
    do_ticks(3);
    chk("R1 ticks before load", 16'd0, 1'b1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      do_reset();
      do_load(VECS[i].mode, VECS[i].val);
      set_gate(1'b1);
      do_ticks(int'(VECS[i].ticks));
      chk($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].cnt, VECS[i].out);
    end

    // R9: gate low stalls mode 0
    do_reset();
    do_load(3'd0, 16'd5);
    set_gate(1'b1);
    do_ticks(2);
    set_gate(1'b0);
    do_ticks(4);
    chk("R9 mode0 gate low holds", 16'd3, 1'b0);

    // R8: rising gate in mode 0 does not restart
    set_gate(1'b1);
    chk("R8 mode0 gate edge ignored", 16'd3, 1'b0);

    // R11: mode 0 load restarts at once
    do_load(3'd0, 16'd9);
    chk("R11 mode0 reload immediate", 16'd9, 1'b0);

    // R9: mode 1 counts with gate low
    do_reset();
    do_load(3'd1, 16'd4);
    set_gate(1'b1);
    set_gate(1'b0);
    do_ticks(2);
    chk("R9 mode1 ignores gate level", 16'd2, 1'b0);

    // R8: mode 5 retrigger
    do_reset();
    do_load(3'd5, 16'd3);
    set_gate(1'b1);
    do_ticks(2);
    chk("R8 mode5 before retrigger", 16'd1, 1'b1);
    set_gate(1'b0);
    set_gate(1'b1);
    chk("R8 mode5 retrigger", 16'd3, 1'b1);
    do_ticks(3);
    chk("R8 mode5 strobe after retrigger", 16'd0, 1'b0);

    // R11: mode 2 same-mode load deferred
    do_reset();
    do_load(3'd2, 16'd4);
    set_gate(1'b1);
    do_ticks(1);
    do_load(3'd2, 16'd2);
    chk("R11 mode2 load deferred", 16'd3, 1'b1);
    do_ticks(3);
    chk("R11 mode2 new value at reload", 16'd2, 1'b1);
    do_ticks(1);
    chk("R11 mode2 new period", 16'd1, 1'b0);

    // R11: mode 1 load waits for trigger
    do_reset();
    do_load(3'd1, 16'd4);
    do_ticks(3);
    chk("R11 mode1 waits for trigger", 16'd0, 1'b1);

    // R7: single strobe per start even across a full wrap
    do_reset();
    do_load(3'd4, 16'd2);
    set_gate(1'b1);
    do_ticks(2);
    chk("R7 mode4 strobe", 16'd0, 1'b0);
    do_ticks(65536);
    chk("R7 mode4 no second strobe", 16'd0, 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule